// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus (I2C-style signalling) that fronts an internal byte-wide memory. Both bus lines are sampled into the system clock domain through a short synchronizer chain. Start and stop conditions and the edges of the serial clock are detected from those samples, and a single state machine walks through the device byte, a two-byte word address and then any number of data bytes. The data line is modelled as an input plus an open-drain pull-down enable. The surrounding chip ties that enable to a pad that can only pull low.

After a start condition, the slave compares the first byte with a fixed device type and with three select pins. If both match, it acknowledges. A write loads the word address latch from the next two bytes and then stores each further byte straight into the array. There is no page buffer and no busy time. A read shifts out bytes from the current address for as long as the master acknowledges. The address latch survives between transactions, so a read that loads no address continues where the last access stopped. A write-protect input blocks all data stores.

The memory depth is 2^ADDR_W bytes. The default of 11 address bits keeps elaboration small, and 13 gives the full 8192-byte array.

Top module: `tw_mem_slave`

## Requirements
- R1: The slave acknowledges the first byte after a start only when its bits 7..4 are 1010 and its bits 3..1 equal sel_i[2:0]. Bit 0 set to 1 means read and cleared to 0 means write. On a mismatch it gives no acknowledge and leaves the data line released until the next start.
- R2: In a write, the two bytes after the device byte form the word address, high byte first. Only the low ADDR_W bits of this 16-bit value are kept, and the higher bits have no effect.
- R3: The address latch advances by one after every data byte, written or read. It wraps from 2^ADDR_W-1 to 0.
- R4: A data byte is stored in the array as soon as its eighth bit is sampled. A start or stop that arrives before the eighth bit leaves the array unchanged.
- R5: While wp_i is high, a write data byte gets no acknowledge, the array is not changed and the address latch does not advance.
- R6: A read sends the byte at the current address and continues with the next byte after each master acknowledge. A master no-acknowledge ends the read and releases the data line.
- R7: A start condition at any point abandons the current operation and waits for a device byte. A stop condition at any point returns the slave to idle.
- R8: Bytes travel most significant bit first. Incoming bits are taken on serial-clock rising edges, and sda_oe_o changes only while the serial clock is low.
- R9: The address latch is kept between transactions. A read that loads no address starts at the address after the last accessed byte.
- R10: Reset clears the address latch to 0 and deasserts sda_oe_o. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| sel_i | input | 3 | Device select pins compared with device-byte bits 3..1 |
| wp_i | input | 1 | Write protect; high blocks all data stores |
| sda_oe_o | output | 1 | Pull the data line low when high |

## Verification
The in-RTL assertions check the following on every cycle:
- sda_oe_o only moves while the sampled serial clock is low.
- Every change of the address latch is either an address load or a step of exactly one, wrapping included.
- A start always leads to the device-byte wait with the line released.
- A stop always leads to idle.
- An idle slave never pulls the line.

Only the bench's bus scenarios can show the following:
- Address matching against the select pins.
- The masking of the high address bits.
- The values stored and read back: ordering, wrap across the top address, protected writes leaving both the data and the address untouched, and aborted bytes.
- The retention of the address across transactions and its clearing by reset.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;
   localparam logic [3:0] DEV_TYPE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DEV, ST_ADRH, ST_ADRL, ST_WDAT, ST_RDAT
   } tw_st_e;

   typedef enum logic [2:0] {
      PH_BITS,   // shifting the eight bits of a byte
      PH_ACKW,   // byte received, drive ACK at next SCL fall
      PH_ACKD,   // ACK driven, release at next SCL fall
      PH_RACKW,  // byte sent, release line at next SCL fall
      PH_RACK,   // sample master ACK on SCL rise
      PH_RNEXT   // master acked, load next byte on SCL fall
   } tw_ph_e;
endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_o      = scl_ff[STAGES-1];
   assign sda_o      = sda_ff[STAGES-1];
   assign scl_rise_o = scl_o & ~scl_q;
   assign scl_fall_o = ~scl_o & scl_q;
   assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
   assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
   import tw_mem_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] sel_i,
   input  logic       wp_i,
   output logic       sda_oe_o
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W must lie in 9..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

   tw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
      .scl_fall_o(scl_fall), .start_o(start_p), .stop_o(stop_p)
   );

   tw_st_e            st_q;
   tw_ph_e            ph_q;
   logic [2:0]        bitcnt_q;
   logic [6:0]        shreg_q;
   logic [HI_W-1:0]   hi_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        outb_q;
   logic              rw_q;
   logic              sda_oe_q;

   logic [7:0]        in_byte, rdata;
   logic [ADDR_W-1:0] addr_load;
   logic              byte_done, dev_match, mem_we, ld_addr;

   assign in_byte   = {shreg_q, sda_s};
   assign addr_load = {hi_q, in_byte};
   assign byte_done = (ph_q == PH_BITS) && scl_rise && (bitcnt_q == 3'd7);
   assign dev_match = (in_byte[7:4] == DEV_TYPE) && (in_byte[3:1] == sel_i);
   assign mem_we    = byte_done && (st_q == ST_WDAT) && !wp_i;
   assign ld_addr   = byte_done && (st_q == ST_ADRL);

   tw_mem_array #(.AW(ADDR_W), .DW(8)) u_mem (
      .clk(clk), .we(mem_we), .addr(addr_q), .wdata(in_byte), .rdata(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         ph_q     <= PH_BITS;
         bitcnt_q <= '0;
         shreg_q  <= '0;
         hi_q     <= '0;
         addr_q   <= '0;
         outb_q   <= '0;
         rw_q     <= 1'b0;
         sda_oe_q <= 1'b0;
      end else if (start_p) begin
         st_q     <= ST_DEV;
         ph_q     <= PH_BITS;
         bitcnt_q <= '0;
         sda_oe_q <= 1'b0;
      end else if (stop_p) begin
         st_q     <= ST_IDLE;
         ph_q     <= PH_BITS;
         bitcnt_q <= '0;
         sda_oe_q <= 1'b0;
      end else begin
         unique case (ph_q)
            PH_BITS: begin
               if (st_q == ST_RDAT) begin
                  if (scl_rise) begin
                     bitcnt_q <= bitcnt_q + 3'd1;
                     if (bitcnt_q == 3'd7) begin
                        addr_q   <= addr_q + 1'b1;
                        ph_q     <= PH_RACKW;
                     end
                  end else if (scl_fall && bitcnt_q != 3'd0) begin
                     sda_oe_q <= ~outb_q[3'd7 - bitcnt_q];
                  end
               end else if (st_q != ST_IDLE && scl_rise) begin
                  shreg_q  <= in_byte[6:0];
                  bitcnt_q <= bitcnt_q + 3'd1;
                  if (bitcnt_q == 3'd7) begin
                     unique case (st_q)
                        ST_DEV: begin
                           if (dev_match) begin
                              rw_q <= in_byte[0];
                              ph_q <= PH_ACKW;
                           end else begin
                              st_q <= ST_IDLE;
                           end
                        end
                        ST_ADRH: begin
                           hi_q <= in_byte[HI_W-1:0];
                           ph_q <= PH_ACKW;
                        end
                        ST_ADRL: begin
                           addr_q <= addr_load;
                           ph_q   <= PH_ACKW;
                        end
                        default: begin
                           if (wp_i) begin
                              st_q <= ST_IDLE;
                           end else begin
                              addr_q <= addr_q + 1'b1;
                              ph_q   <= PH_ACKW;
                           end
                        end
                     endcase
                  end
               end
            end
            PH_ACKW: if (scl_fall) begin
               sda_oe_q <= 1'b1;
               ph_q     <= PH_ACKD;
            end
            PH_ACKD: if (scl_fall) begin
               sda_oe_q <= 1'b0;
               ph_q     <= PH_BITS;
               bitcnt_q <= '0;
               unique case (st_q)
                  ST_DEV: begin
                     if (rw_q) begin
                        st_q     <= ST_RDAT;
                        outb_q   <= rdata;
                        sda_oe_q <= ~rdata[7];
                     end else begin
                        st_q <= ST_ADRH;
                     end
                  end
                  ST_ADRH: st_q <= ST_ADRL;
                  ST_ADRL: st_q <= ST_WDAT;
                  default: st_q <= st_q;
               endcase
            end
            PH_RACKW: if (scl_fall) begin
               sda_oe_q <= 1'b0;
               ph_q     <= PH_RACK;
            end
            PH_RACK: if (scl_rise) begin
               if (!sda_s) begin
                  ph_q <= PH_RNEXT;
               end else begin
                  st_q <= ST_IDLE;
                  ph_q <= PH_BITS;
               end
            end
            default: if (scl_fall) begin
               outb_q   <= rdata;
               sda_oe_q <= ~rdata[7];
               ph_q     <= PH_BITS;
               bitcnt_q <= '0;
            end
         endcase
      end
   end

   assign sda_oe_o = sda_oe_q;

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_q) |-> !scl_s);                              // R8
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(addr_q) && !$past(ld_addr)) |-> addr_q == $past(addr_q) + 1'b1); // R3
   AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> (st_q == ST_DEV) && !sda_oe_q);                  // R7
   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> (st_q == ST_IDLE) && !sda_oe_q);                  // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !sda_oe_q);                            // R1
endmodule

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic [2:0] sel = 3'b101;
   logic wp = 1'b0;
   logic sda_oe;
   wire  sda_bus = m_sda & ~sda_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct { string tag; int val; } item_t;
   item_t exp_q[$];
   item_t obs_q[$];

   always #2 clk = ~clk;

   tw_mem_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .sel_i(sel), .wp_i(wp), .sda_oe_o(sda_oe)
   );

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_exp(input string t, input int v);
      item_t it;
      it.tag = t; it.val = v;
      exp_q.push_back(it);
   endtask

   task automatic push_obs(input int v);
      item_t it;
      it.tag = ""; it.val = v;
      obs_q.push_back(it);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(Q); scl = 1'b1; wq(2*Q);
      m_sda = 1'b0; wq(2*Q); scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(Q); scl = 1'b1; wq(2*Q);
      m_sda = 1'b1; wq(2*Q);
   endtask

   task automatic bit_out(input logic b);
      m_sda = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
   endtask

   task automatic bit_in(output logic b);
      m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
      b = sda_bus; wq(Q); scl = 1'b0; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, input string t, input int exp_ack);
      logic a;
      push_exp(t, exp_ack);
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(a);
      push_obs(a ? 0 : 1);
   endtask

   task automatic recv_byte(input string t, input logic [7:0] expv, input logic mack);
      logic [7:0] v;
      logic b;
      push_exp(t, int'(expv));
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         v[i] = b;
      end
      push_obs(int'(v));
      bit_out(~mack);
   endtask

   task automatic direct_check(input string t, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", t, act, expv);
      end
   endtask

   task automatic write_one(input logic [15:0] a, input logic [7:0] d);
      bus_start();
      send_byte(8'hAA, "R1", 1);
      send_byte(a[15:8], "R2", 1);
      send_byte(a[7:0], "R2", 1);
      send_byte(d, "R4", 1);
      bus_stop();
   endtask

   task automatic set_addr_restart(input logic [15:0] a);
      bus_start();
      send_byte(8'hAA, "R1", 1);
      send_byte(a[15:8], "R2", 1);
      send_byte(a[7:0], "R2", 1);
      bus_start();
      send_byte(8'hAB, "R7", 1);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0 && obs_q.size() > 0) begin
            item_t e;
            item_t o;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            checks++;
            if (e.val != o.val) begin
               errors++;
               $display("FAIL %s: got %0h expected %0h", e.tag, o.val, e.val);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (R1..R10 incomplete): got timeout expected completion");
         report();
      end
   end

   initial begin
      wq(5);
      rst_n = 1'b1;
      wq(5);
      direct_check("R10 oe after reset", int'(sda_oe), 0);

      // R2: high address bits ignored (F810 -> 010); R4/R8 sequential store
      bus_start();
      send_byte(8'hAA, "R1", 1);
      send_byte(8'hF8, "R2", 1);
      send_byte(8'h10, "R2", 1);
      send_byte(8'h11, "R4", 1);
      send_byte(8'h22, "R4", 1);
      send_byte(8'h33, "R4", 1);
      send_byte(8'h44, "R4", 1);
      bus_stop();
      write_one(16'h0020, 8'h99);
      write_one(16'h0030, 8'h12);

      // R6/R8: random read of three bytes, NACK ends
      set_addr_restart(16'h0010);
      recv_byte("R8 msb first", 8'h11, 1'b1);
      recv_byte("R6", 8'h22, 1'b1);
      recv_byte("R6", 8'h33, 1'b0);
      wq(2);
      direct_check("R6 line released after NACK", int'(sda_oe), 0);
      bus_stop();

      // R9: current-address read continues at 0x013
      bus_start();
      send_byte(8'hAB, "R1", 1);
      recv_byte("R9", 8'h44, 1'b0);
      bus_stop();

      // R3: wrap from top address to zero
      bus_start();
      send_byte(8'hAA, "R1", 1);
      send_byte(8'h07, "R2", 1);
      send_byte(8'hFF, "R2", 1);
      send_byte(8'hA5, "R3", 1);
      send_byte(8'h5C, "R3", 1);
      bus_stop();
      set_addr_restart(16'h07FF);
      recv_byte("R3 top", 8'hA5, 1'b1);
      recv_byte("R3 wrapped", 8'h5C, 1'b0);
      bus_stop();

      // R1: select mismatch gets no ACK, following byte ignored
      bus_start();
      send_byte(8'hA2, "R1 mismatch", 0);
      send_byte(8'h00, "R1 ignored", 0);
      bus_stop();
      bus_start();
      send_byte(8'hBA, "R1 wrong type", 0);
      bus_stop();

      // R5: protected write NACKed, no store, no increment
      wp = 1'b1;
      bus_start();
      send_byte(8'hAA, "R1", 1);
      send_byte(8'h00, "R5", 1);
      send_byte(8'h20, "R5", 1);
      send_byte(8'h77, "R5 nack", 0);
      bus_stop();
      wp = 1'b0;
      bus_start();
      send_byte(8'hAB, "R1", 1);
      recv_byte("R5 unchanged/no inc", 8'h99, 1'b0);
      bus_stop();

      // R4/R7: stop after five bits leaves memory intact
      bus_start();
      send_byte(8'hAA, "R1", 1);
      send_byte(8'h00, "R2", 1);
      send_byte(8'h30, "R2", 1);
      for (int i = 0; i < 5; i++) bit_out(1'b1);
      bus_stop();
      set_addr_restart(16'h0030);
      recv_byte("R4 stop abort", 8'h12, 1'b0);
      bus_stop();

      // R7: start after four bits aborts, read continues at loaded address
      bus_start();
      send_byte(8'hAA, "R1", 1);
      send_byte(8'h00, "R2", 1);
      send_byte(8'h30, "R2", 1);
      for (int i = 0; i < 4; i++) bit_out(1'b0);
      bus_start();
      send_byte(8'hAB, "R7", 1);
      recv_byte("R7 start abort", 8'h12, 1'b0);
      bus_stop();

      // R10: reset returns address latch to zero, memory kept
      write_one(16'h0000, 8'h5A);
      write_one(16'h0005, 8'h66);
      rst_n = 1'b0;
      wq(5);
      rst_n = 1'b1;
      wq(5);
      direct_check("R10 oe after second reset", int'(sda_oe), 0);
      bus_start();
      send_byte(8'hAB, "R1", 1);
      recv_byte("R10 address cleared", 8'h5A, 1'b0);
      bus_stop();

      wq(10);
      direct_check("R6 scoreboard drained", exp_q.size() + obs_q.size(), 0);
      done = 1'b1;
      report();
   end
endmodule